// File: doc/BRIEF.md
# Interrupt Source Controller

This block holds the state for a parameterized set of interrupt sources and turns their activity into requests for presenters. Each source is either level-sensitive or edge/message-signalled. The type is fixed per source by a parameter mask. Every source keeps a target server, a priority and a saved priority. It also keeps four delivery flags: asserted, sent, rejected and masked-pending. A priority of 0xFF masks the source. A masked message-signalled trigger is latched and delivered once the source is unmasked.

A present request carries a server, a global source number and a priority. The global number is the local index plus the parameter `BASE`. Requests leave on a valid/ready port, one at a time. When several sources are waiting, the lowest index goes first. Presenters answer with reject and end-of-interrupt messages that carry global numbers. The block maps each one back to a local source, and the source type decides the effect.

A resend-all request starts a scanner. The scanner visits one source per cycle and applies that source's resend rule. It pauses while the output is stalled, and it pauses while an incoming event touches the source it is pointing at. A readback port returns the configuration of one source.

Top module: `irq_source_ctl`

## Requirements
- R1: A message-signalled trigger on an unmasked source presents that source's server, the number index+BASE and its priority.
- R2: A message-signalled trigger on a source with priority 0xFF presents nothing and latches. A later configuration write with a priority other than 0xFF presents the source once, and a further write presents nothing more.
- R3: A level source with a priority other than 0xFF is presented once when its input rises. While the input stays high it is not presented again, and a falling input presents nothing.
- R4: A reject of a message-signalled source marks it. The next resend-all presents it again, and a following resend-all presents nothing more. A source that was not rejected is never re-presented by resend-all.
- R5: A reject or end-of-interrupt of a level source clears its sent state. A resend-all while the input is still high then presents it again. A configuration write that unmasks an asserted level source that has not been sent presents it.
- R6: An end-of-interrupt naming a message-signalled source has no effect; a later resend-all presents nothing.
- R7: While `pres_valid` is high and `pres_ready` is low, the request stays unchanged, and other waiting sources queue behind it.
- R8: Sources that become ready in the same cycle are presented lowest index first.
- R9: After reset no request is valid. Every server reads back 0, and every priority and saved priority reads back 0xFF.
- R10: Reject and end-of-interrupt numbers below BASE or at BASE+NSRC and above are ignored.
- R11: A configuration write to a source is returned by the readback port for that index (server, priority, saved priority).
- R12: A presented request never carries priority 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_trig | input | NSRC | Per-source trigger pulse (message-signalled sources) |
| lvl_in | input | NSRC | Per-source input level (level sources) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index written |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| cfg_saved | input | 8 | New saved priority |
| rej_valid | input | 1 | Reject message strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Start a resend-all scan |
| rd_idx | input | IDX_W | Readback index |
| rd_server | output | SRV_W | Server of source rd_idx |
| rd_prio | output | 8 | Priority of source rd_idx |
| rd_saved | output | 8 | Saved priority of source rd_idx |
| pres_valid | output | 1 | Present request valid |
| pres_ready | input | 1 | Presenter accepts request |
| pres_server | output | SRV_W | Target server of request |
| pres_num | output | NUM_W | Global source number of request |
| pres_prio | output | 8 | Priority of request |

## Verification
The hardest states to reach from the ports are those where a source's hidden flag decides the outcome of a later resend-all. Examples are a rejected message-signalled source, or a level source whose sent state was cleared while its input stays high. The stimulus builds these states in sequence: present, then reject or complete, then resend. A second resend-all afterwards confirms that each flag is consumed exactly once. Masked-pending is reached by triggering under priority 0xFF and then unmasking. Output back-pressure is created by holding ready low while further triggers arrive.

// File: rtl/irq_source_ctl.sv
module irq_source_ctl #(
  parameter int NSRC  = 8,
  parameter int SRV_W = 4,
  parameter int NUM_W = 12,
  parameter int BASE  = 16,
  parameter logic [NSRC-1:0] LVL_MASK = {{(NSRC - NSRC/2){1'b1}}, {(NSRC/2){1'b0}}},
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  msi_trig,
  input  logic [NSRC-1:0]  lvl_in,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic [7:0]       cfg_saved,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend_req,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SRV_W-1:0] rd_server,
  output logic [7:0]       rd_prio,
  output logic [7:0]       rd_saved,
  output logic             pres_valid,
  input  logic             pres_ready,
  output logic [SRV_W-1:0] pres_server,
  output logic [NUM_W-1:0] pres_num,
  output logic [7:0]       pres_prio
);
  localparam logic [7:0] MASKED = 8'hFF;

  logic [SRV_W-1:0] srv_q [NSRC];
  logic [7:0]       prio_q [NSRC];
  logic [7:0]       sav_q [NSRC];
  logic [NSRC-1:0]  asrt_q, sent_q, rej_q, mp_q, want_q;
  logic [SRV_W-1:0] srv_d [NSRC];
  logic [7:0]       prio_d [NSRC];
  logic [7:0]       sav_d [NSRC];
  logic [NSRC-1:0]  asrt_d, sent_d, rej_d, mp_d, want_d, new_want, elig;

  logic             scan_on;
  logic [IDX_W-1:0] scan_ptr;
  logic             scan_go, busy, stall, load;
  logic [IDX_W-1:0] gi;

  wire [NUM_W-1:0] rej_loc = rej_num - NUM_W'(BASE);
  wire [NUM_W-1:0] eoi_loc = eoi_num - NUM_W'(BASE);
  wire rej_hit = rej_valid && rej_num >= NUM_W'(BASE) && rej_num < NUM_W'(BASE + NSRC);
  wire eoi_hit = eoi_valid && eoi_num >= NUM_W'(BASE) && eoi_num < NUM_W'(BASE + NSRC);
  wire [NSRC-1:0] lvl_evt = (lvl_in ^ asrt_q) & LVL_MASK;
  wire [NSRC-1:0] touch   = (msi_trig & ~LVL_MASK) | lvl_evt;

  assign rd_server = srv_q[rd_idx];
  assign rd_prio   = prio_q[rd_idx];
  assign rd_saved  = sav_q[rd_idx];

  assign stall = pres_valid && !pres_ready;
  assign busy  = (cfg_we && cfg_idx == scan_ptr) || touch[scan_ptr]
              || (rej_hit && rej_loc == NUM_W'(scan_ptr))
              || (eoi_hit && eoi_loc == NUM_W'(scan_ptr));
  assign scan_go = scan_on && !stall && !busy;

  always_comb begin
    gi = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      elig[i] = want_q[i] && prio_q[i] != MASKED;
      if (elig[i]) gi = IDX_W'(i);
    end
    load = (!pres_valid || pres_ready) && |elig;
  end

  always_comb begin
    asrt_d = asrt_q; sent_d = sent_q; rej_d = rej_q; mp_d = mp_q;
    new_want = '0;
    for (int i = 0; i < NSRC; i++) begin
      srv_d[i] = srv_q[i]; prio_d[i] = prio_q[i]; sav_d[i] = sav_q[i];
      if (cfg_we && cfg_idx == IDX_W'(i)) begin
        srv_d[i] = cfg_server; prio_d[i] = cfg_prio; sav_d[i] = cfg_saved;
        if (!LVL_MASK[i] && mp_d[i] && cfg_prio != MASKED) begin
          mp_d[i] = 1'b0; new_want[i] = 1'b1;
        end
        if (LVL_MASK[i] && prio_d[i] != MASKED && asrt_d[i] && !sent_d[i]) begin
          sent_d[i] = 1'b1; new_want[i] = 1'b1;
        end
      end
      if (lvl_evt[i]) begin
        asrt_d[i] = lvl_in[i];
        if (prio_d[i] != MASKED && asrt_d[i] && !sent_d[i]) begin
          sent_d[i] = 1'b1; new_want[i] = 1'b1;
        end
      end
      if (!LVL_MASK[i] && msi_trig[i]) begin
        if (prio_d[i] == MASKED) mp_d[i] = 1'b1;
        else new_want[i] = 1'b1;
      end
      if (rej_hit && rej_loc == NUM_W'(i)) begin
        if (LVL_MASK[i]) sent_d[i] = 1'b0;
        else rej_d[i] = 1'b1;
      end
      if (eoi_hit && eoi_loc == NUM_W'(i) && LVL_MASK[i]) sent_d[i] = 1'b0;
      if (scan_go && scan_ptr == IDX_W'(i)) begin
        if (LVL_MASK[i]) begin
          if (prio_d[i] != MASKED && asrt_d[i] && !sent_d[i]) begin
            sent_d[i] = 1'b1; new_want[i] = 1'b1;
          end
        end else if (rej_d[i]) begin
          rej_d[i] = 1'b0;
          if (prio_d[i] != MASKED) new_want[i] = 1'b1;
        end
      end
    end
    want_d = want_q;
    if (load) want_d[gi] = 1'b0;
    want_d = want_d | new_want;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        srv_q[i] <= '0; prio_q[i] <= MASKED; sav_q[i] <= MASKED;
      end
      asrt_q <= '0; sent_q <= '0; rej_q <= '0; mp_q <= '0; want_q <= '0;
      scan_on <= 1'b0; scan_ptr <= '0;
      pres_valid <= 1'b0; pres_server <= '0; pres_num <= '0; pres_prio <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        srv_q[i] <= srv_d[i]; prio_q[i] <= prio_d[i]; sav_q[i] <= sav_d[i];
      end
      asrt_q <= asrt_d; sent_q <= sent_d; rej_q <= rej_d; mp_q <= mp_d; want_q <= want_d;
      if (resend_req) begin
        scan_on <= 1'b1; scan_ptr <= '0;
      end else if (scan_go) begin
        if (scan_ptr == IDX_W'(NSRC - 1)) scan_on <= 1'b0;
        else scan_ptr <= scan_ptr + 1'b1;
      end
      if (load) begin
        pres_valid  <= 1'b1;
        pres_server <= srv_q[gi];
        pres_num    <= NUM_W'(BASE) + NUM_W'(gi);
        pres_prio   <= prio_q[gi];
      end else if (pres_ready) begin
        pres_valid <= 1'b0;
      end
    end
  end
endmodule

module irq_source_ctl_chk #(
  parameter int NSRC  = 8,
  parameter int SRV_W = 4,
  parameter int NUM_W = 12,
  parameter int BASE  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pres_valid,
  input logic             pres_ready,
  input logic [SRV_W-1:0] pres_server,
  input logic [NUM_W-1:0] pres_num,
  input logic [7:0]       pres_prio
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid && !pres_ready |=> pres_valid && $stable(pres_num)
      && $stable(pres_server) && $stable(pres_prio));
  // R12
  prio_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> pres_prio != 8'hFF);
  // R1
  num_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> pres_num >= NUM_W'(BASE) && pres_num < NUM_W'(BASE + NSRC));
  // R9
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !pres_valid);
endmodule

bind irq_source_ctl irq_source_ctl_chk #(.NSRC(NSRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pres_valid(pres_valid), .pres_ready(pres_ready),
  .pres_server(pres_server), .pres_num(pres_num), .pres_prio(pres_prio));

// File: tb/irq_source_ctl_tb.sv
module irq_source_ctl_tb;
  localparam int NSRC = 8, SRV_W = 4, NUM_W = 12, BASE = 16, IDX_W = 3;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] msi_trig = '0, lvl_in = '0;
  logic cfg_we = 0; logic [IDX_W-1:0] cfg_idx = '0;
  logic [SRV_W-1:0] cfg_server = '0; logic [7:0] cfg_prio = '0, cfg_saved = '0;
  logic rej_valid = 0, eoi_valid = 0, resend_req = 0;
  logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [SRV_W-1:0] rd_server; logic [7:0] rd_prio, rd_saved;
  logic pres_valid, pres_ready = 1;
  logic [SRV_W-1:0] pres_server; logic [NUM_W-1:0] pres_num; logic [7:0] pres_prio;

  int checks = 0, fails = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irq_source_ctl u_dut (.*);

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_pres(string tag, int srv, int num, int prio);
    exp_q.push_back({SRV_W'(srv), NUM_W'(num), 8'(prio)});
    tag_q.push_back(tag);
  endtask

  task automatic drain(string tag);
    tick(12);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic pulse_msi(logic [NSRC-1:0] m);
    msi_trig = m; tick(1); msi_trig = '0;
  endtask

  task automatic cfg(int idx, int srv, int prio, int sav);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_server = SRV_W'(srv);
    cfg_prio = 8'(prio); cfg_saved = 8'(sav);
    tick(1); cfg_we = 0;
  endtask

  task automatic rej(int num);
    rej_valid = 1; rej_num = NUM_W'(num); tick(1); rej_valid = 0;
  endtask

  task automatic eoi(int num);
    eoi_valid = 1; eoi_num = NUM_W'(num); tick(1); eoi_valid = 0;
  endtask

  task automatic resend();
    resend_req = 1; tick(1); resend_req = 0; tick(NSRC + 4);
  endtask

  always @(negedge clk) begin
    if (rst_n && pres_valid && pres_ready) begin
      logic [23:0] got, e;
      string t;
      got = {pres_server, pres_num, pres_prio};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected present: actual %0h expected none", got);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          fails++;
          $display("FAIL %s: actual %0h expected %0h", t, got, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R9 reset state
    check(pres_valid == 0, "R9 valid", pres_valid, 0);
    rd_idx = 3; #1;
    check(rd_server == 0, "R9 server", rd_server, 0);
    check(rd_prio == 8'hFF && rd_saved == 8'hFF, "R9 prio", {rd_prio, rd_saved}, 16'hFFFF);

    // R11 readback, R1 basic present
    cfg(0, 2, 5, 7);
    rd_idx = 0; #1;
    check({rd_server, rd_prio, rd_saved} == {4'd2, 8'd5, 8'd7}, "R11 readback",
          {rd_server, rd_prio, rd_saved}, {4'd2, 8'd5, 8'd7});
    expect_pres("R1 msi", 2, 16, 5);
    pulse_msi(8'h01);
    drain("R1 drain");

    // R2 masked-pending
    cfg(1, 3, 8'hFF, 8'hFF);
    pulse_msi(8'h02);
    drain("R2 masked silent");
    expect_pres("R2 unmask", 3, 17, 4);
    cfg(1, 3, 4, 4);
    drain("R2 unmask drain");
    cfg(1, 3, 6, 6);
    drain("R2 single delivery");

    // R8 lowest index first
    cfg(2, 1, 9, 9);
    expect_pres("R8 first", 2, 16, 5);
    expect_pres("R8 second", 1, 18, 9);
    pulse_msi(8'h05);
    drain("R8 drain");

    // R4 reject then resend
    rej(18);
    expect_pres("R4 resend", 1, 18, 9);
    resend();
    drain("R4 drain");
    resend();
    drain("R4 consumed");

    // R3 level source
    cfg(4, 5, 3, 3);
    expect_pres("R3 rise", 5, 20, 3);
    lvl_in[4] = 1; tick(1);
    drain("R3 drain");
    resend();
    drain("R3 no repeat");
    // R5 reject / eoi of level
    rej(20);
    expect_pres("R5 after reject", 5, 20, 3);
    resend();
    drain("R5 reject drain");
    eoi(20);
    expect_pres("R5 after eoi", 5, 20, 3);
    resend();
    drain("R5 eoi drain");
    lvl_in[4] = 0; tick(1);
    eoi(20);
    resend();
    drain("R3 fall silent");
    cfg(5, 6, 8'hFF, 8'hFF);
    lvl_in[5] = 1; tick(1);
    drain("R5 masked level");
    expect_pres("R5 cfg unmask", 6, 21, 2);
    cfg(5, 6, 2, 2);
    drain("R5 cfg drain");

    // R6 eoi on message source
    eoi(16);
    resend();
    drain("R6 no effect");

    // R10 out-of-range numbers
    rej(24); rej(15); eoi(24);
    resend();
    drain("R10 ignored");

    // R7 back-pressure
    pres_ready = 0;
    expect_pres("R7 held", 2, 16, 5);
    expect_pres("R7 queued", 1, 18, 9);
    pulse_msi(8'h01);
    tick(5);
    check(pres_valid == 1 && pres_num == 16, "R7 stall", {pres_valid, pres_num}, {1'b1, 12'd16});
    pulse_msi(8'h04);
    tick(4);
    check(pres_valid == 1 && pres_num == 16, "R7 stable", {pres_valid, pres_num}, {1'b1, 12'd16});
    pres_ready = 1;
    drain("R7 drain");

    // R9 reset mid-run
    lvl_in = '0; tick(1);
    rst_n = 0; tick(2); rst_n = 1; tick(1);
    check(pres_valid == 0, "R9 valid after reset", pres_valid, 0);
    rd_idx = 0; #1;
    check(rd_server == 0 && rd_prio == 8'hFF && rd_saved == 8'hFF, "R9 cleared",
          {rd_server, rd_prio, rd_saved}, {4'd0, 8'hFF, 8'hFF});
    pulse_msi(8'h01);
    drain("R9 masked after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule